// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive. After reset it waits out a fixed start-up pause. It then runs a set number of wake-up strobe cycles and only afterwards raises `ready` to the host. From then on an interval counter marks each moment a row refresh is owed. Each owed refresh is performed as a CAS-before-RAS cycle: CAS falls first and RAS follows. The device then supplies the row address itself, so no address or data lines are involved.

The block shares the RAS/CAS lines with an access sequencer through a request/grant pair. When a cycle is owed it raises `bus_req`. It drives the strobes only after `bus_gnt` comes back, and `ref_own` tells the surrounding mux whose strobes reach the pins. If the grant is withheld, owed refreshes pile up to a bounded backlog. One more interval beyond that bound sets a sticky error flag, drops `ready` and repeats the wake-up sequence. With default parameters at 50 MHz, the block waits 200 µs, runs 8 wake cycles and owes one refresh every 780 clocks, which covers 2048 rows in under 32 ms.

Top module: `dram_refresh_ctl`

## Requirements
- R1: While reset is asserted, `ram_ras_n` and `ram_cas_n` are 1, and `bus_req`, `ref_own`, `ready` and `err` are 0.
- R2: After reset is released, `bus_req` stays 0 for the first PAUSE_CYC-1 clock edges and is 1 after edge PAUSE_CYC.
- R3: A strobe cycle starts (`ref_own` rises) only on a clock edge at which both `bus_req` and `bus_gnt` were 1. Once started, it runs to the end whatever `bus_gnt` does.
- R4: Each strobe cycle holds `ram_cas_n`=0 with `ram_ras_n`=1 for CAS_LEAD clocks, then both at 0 for RAS_LOW clocks, then both at 1 for PRE_CYC clocks, all with `ref_own`=1.
- R5: Whenever `ref_own` is 0, `ram_ras_n` and `ram_cas_n` are both 1.
- R6: Exactly WAKE_CYCLES strobe cycles run before `ready` rises. `ready` goes to 1 on the same edge that `ref_own` falls after the last of them.
- R7: While `ready` is 1, one refresh becomes owed every REF_INT clocks, and each owed refresh is later performed as one strobe cycle.
- R8: While the grant is withheld, up to MAX_PEND owed refreshes are kept. All of them are performed once the grant returns, and `ready` stays 1 throughout.
- R9: If a refresh comes due while MAX_PEND are already owed, then on that edge `err` is set and stays set until reset, `ready` drops, the backlog is discarded and WAKE_CYCLES wake cycles are owed again.
- R10: `bus_req` is 0 in the clock right after `ref_own` falls, so the access sequencer can win the bus between two back-to-back strobe cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Grant from the access sequencer, given at an access boundary |
| bus_req | output | 1 | Request for the strobe lines |
| ref_own | output | 1 | High while this block drives RAS/CAS |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Wake-up complete, accesses allowed |
| err | output | 1 | Sticky refresh-backlog overflow |

## Verification
The bench samples on the falling clock edge. A result caused by a rising edge is therefore read half a clock later.

A granted request shows up as `ref_own` one edge after the grant is seen. The strobe phases then last exactly CAS_LEAD, RAS_LOW and PRE_CYC samples. `bus_req` is low at the very sample where `ref_own` is first seen low. The first `bus_req` after reset appears at sample PAUSE_CYC.

The bench's interval model counts the samples at which `ready` is high and predicts each owed refresh for the following edge. An overflow is predicted in the same way, and the bench expects `err` high and `ready` low one sample after that prediction.

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl #(
  parameter int PAUSE_CYC   = 10000,
  parameter int WAKE_CYCLES = 8,
  parameter int REF_INT     = 780,
  parameter int CAS_LEAD    = 2,
  parameter int RAS_LOW     = 4,
  parameter int PRE_CYC     = 3,
  parameter int MAX_PEND    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ref_own,
  output logic ram_ras_n,
  output logic ram_cas_n,
  output logic ready,
  output logic err
);
  localparam int TW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(REF_INT + 1);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_LEAD, S_STROBE, S_PRE, S_GAP} st_t;

  st_t st;
  logic [TW-1:0] tmr;
  logic [IW-1:0] icnt;
  logic [PW-1:0] pend;
  logic [WW-1:0] wake_left;

  wire tmr_done = (tmr == '0);
  wire need     = (wake_left != '0) || (pend != '0);
  wire start    = (st == S_IDLE) && need && bus_gnt;
  wire fin      = (st == S_PRE) && tmr_done;
  wire tick     = ready && (icnt == IW'(REF_INT - 1));
  wire ovf      = tick && (pend == PW'(MAX_PEND));
  wire served   = fin && (wake_left == '0) && (pend != '0);

  assign ref_own   = (st == S_LEAD) || (st == S_STROBE) || (st == S_PRE);
  assign bus_req   = ((st == S_IDLE) && need) || ref_own;
  assign ram_cas_n = !((st == S_LEAD) || (st == S_STROBE));
  assign ram_ras_n = (st != S_STROBE);
  assign ready     = (wake_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_PAUSE;
      tmr <= TW'(PAUSE_CYC - 1);
    end else begin
      case (st)
        S_PAUSE:  if (tmr_done) st <= S_IDLE; else tmr <= tmr - 1'b1;
        S_IDLE:   if (start) begin st <= S_LEAD; tmr <= TW'(CAS_LEAD - 1); end
        S_LEAD:   if (tmr_done) begin st <= S_STROBE; tmr <= TW'(RAS_LOW - 1); end
                  else tmr <= tmr - 1'b1;
        S_STROBE: if (tmr_done) begin st <= S_PRE; tmr <= TW'(PRE_CYC - 1); end
                  else tmr <= tmr - 1'b1;
        S_PRE:    if (tmr_done) st <= S_GAP; else tmr <= tmr - 1'b1;
        default:  st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_left <= WW'(WAKE_CYCLES);
      pend      <= '0;
      icnt      <= '0;
      err       <= 1'b0;
    end else begin
      icnt <= (!ready || tick) ? '0 : icnt + 1'b1;
      if (ovf) begin
        err       <= 1'b1;
        wake_left <= WW'(WAKE_CYCLES);
        pend      <= '0;
      end else begin
        if (fin && wake_left != '0) wake_left <= wake_left - 1'b1;
        if (tick && !served)        pend <= pend + 1'b1;
        else if (!tick && served)   pend <= pend - 1'b1;
      end
    end
  end

  assert_lines_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_own |-> (ram_ras_n && ram_cas_n));
  assert_start_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_own) |-> $past(bus_req && bus_gnt));
  assert_ready_after_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $fell(ref_own));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_backlog_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAX_PEND));
  assert_gap_after_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_own) |-> !bus_req);
  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> $past(!ram_cas_n));
endmodule

// File: tb/sim_dram_refresh_ctl.sv
`timescale 1ns/1ps
module sim_dram_refresh_ctl;
  localparam int PAUSE = 50, WAKE = 8, RINT = 40, LEAD = 2, LOW = 4, PRE = 3, MAXP = 3;

  logic clk = 0, rst_n = 0, bus_gnt = 0, hold = 0;
  logic bus_req, ref_own, ram_ras_n, ram_cas_n, ready, err;
  int vectors = 0, miscompares = 0, mpend = 0, mcnt = 0, refdone = 0;
  bit q[$];
  bit finished = 0;

  dram_refresh_ctl #(.PAUSE_CYC(PAUSE), .WAKE_CYCLES(WAKE), .REF_INT(RINT),
    .CAS_LEAD(LEAD), .RAS_LOW(LOW), .PRE_CYC(PRE), .MAX_PEND(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req), .ref_own(ref_own),
    .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ready(ready), .err(err));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial forever begin
    @(negedge clk);
    #1 bus_gnt = bus_req && !hold;
  end

  initial begin : monitor
    bit prev_own = 0, prev_req = 0, exp_ovf = 0, item, last;
    int lead = 0, low = 0, pre = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin prev_own = 0; prev_req = 0; mcnt = 0; continue; end
      if (!ref_own)
        chk(ram_ras_n && ram_cas_n, "R5 strobes idle", {ram_ras_n, ram_cas_n}, 3);
      if (ref_own && !prev_own) begin
        chk(bus_gnt && prev_req, "R3 start needs req and gnt", {prev_req, bus_gnt}, 3);
        lead = 0; low = 0; pre = 0;
      end
      if (ref_own) begin
        if (!ram_cas_n && ram_ras_n) lead++;
        else if (!ram_cas_n && !ram_ras_n) low++;
        else if (ram_cas_n && ram_ras_n) pre++;
      end
      if (!ref_own && prev_own) begin
        chk(lead == LEAD, "R4 cas lead", lead, LEAD);
        chk(low == LOW, "R4 ras low", low, LOW);
        chk(pre == PRE, "R4 precharge", pre, PRE);
        chk(!bus_req, "R10 req gap", bus_req, 0);
        if (q.size() == 0) chk(0, "R7 unexpected cycle", 1, 0);
        else begin
          item = q.pop_front();
          if (item == 0) begin
            last = (q.size() == 0) || (q[0] == 1);
            chk(ready == last, "R6 ready after wake", ready, last);
          end else begin
            chk(ready, "R8 ready during refresh", ready, 1);
            mpend--; refdone++;
          end
        end
      end
      if (exp_ovf) begin
        chk(err && !ready, "R9 overflow err/ready", {err, ready}, 2);
        exp_ovf = 0;
      end
      if (ready) begin
        mcnt++;
        if (mcnt == RINT) begin
          mcnt = 0;
          if (mpend == MAXP) begin
            exp_ovf = 1; q.delete(); mpend = 0;
            repeat (WAKE) q.push_back(0);
          end else begin
            q.push_back(1); mpend++;
          end
        end
      end else mcnt = 0;
      prev_own = ref_own; prev_req = bus_req;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin : driver
    int r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ram_ras_n && ram_cas_n, "R1 strobes high", {ram_ras_n, ram_cas_n}, 3);
    chk(!bus_req && !ref_own, "R1 no request", {bus_req, ref_own}, 0);
    chk(!ready && !err, "R1 flags low", {ready, err}, 0);
    repeat (WAKE) q.push_back(0);
    rst_n = 1;
    // R2 pause length
    repeat (PAUSE - 1) @(negedge clk);
    chk(!bus_req, "R2 still pausing", bus_req, 0);
    @(negedge clk);
    chk(bus_req, "R2 pause ends", bus_req, 1);
    while (!ready) @(negedge clk);
    chk(q.size() == 0, "R6 all wake cycles done", q.size(), 0);
    // R7 free-running refresh pacing
    r0 = refdone;
    repeat (5 * RINT) @(negedge clk);
    chk(refdone - r0 >= 4 && refdone - r0 <= 6, "R7 refresh count", refdone - r0, 5);
    // R3 grant withdrawn mid-cycle, R8 backlog
    @(posedge ref_own);
    @(negedge clk);
    hold = 1;
    repeat (100) @(negedge clk);
    chk(!ref_own, "R8 no cycle while withheld", ref_own, 0);
    chk(mpend >= 2, "R8 backlog built", mpend, 2);
    chk(ready && !err, "R8 ready kept", {ready, err}, 2);
    hold = 0;
    repeat (60) @(negedge clk);
    chk(ready && !err, "R8 backlog drained", {ready, err}, 2);
    chk(mpend <= 1, "R8 backlog served", mpend, 0);
    // R9 overflow
    hold = 1;
    repeat (4 * RINT + 20) @(negedge clk);
    chk(err && !ready, "R9 overflow state", {err, ready}, 2);
    hold = 0;
    while (!ready) @(negedge clk);
    chk(q.size() == 0, "R9 wake repeated", q.size(), 0);
    repeat (3 * RINT) @(negedge clk);
    chk(err, "R9 err sticky", err, 1);
    chk(q.size() <= 1, "R7 no refresh lost", q.size(), 0);
    finish_run();
  end
endmodule